// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit timer channel with six operating modes. A count-load strobe captures a start value together with a mode and a number format, binary or four BCD digits. From then on the channel measures the ticks that have elapsed since the load. A tick is a clock cycle on which the counter-clock enable is high. From that elapsed count the channel derives the OUT waveform for the selected mode and a live count value for readback. The gate input plays a different part in each mode: it can pause counting, restart counting, or have no effect.

The six modes are: interrupt on terminal count (0), hardware one-shot (1), rate generator (2), square wave (3), software strobe (4) and hardware strobe (5). The load strobe is sampled on every clock cycle and cannot be held off, so the channel has no back-pressure. When a load and a tick arrive in the same cycle, the load wins. Host bus decoding and byte sequencing belong to a separate register interface block.

Top module: `pit_channel`

## Requirements
- R1: A synchronous active-high reset puts the channel in its unloaded state, with OUT low and count 0. Until the first load, ticks and gate activity change neither output.
- R2: On the cycle after a load strobe, the count shows the loaded start value and elapsed-tick measurement restarts from zero. The mode and format are captured at the load. A load in the middle of a run discards the old run.
- R3: A loaded value of zero stands for 65536 ticks in binary format and 10000 ticks in BCD format.
- R4: Elapsed ticks advance only on cycles where cnt_en is high.
- R5: In mode 0, OUT is low after the load and goes high, and stays high, once the elapsed ticks reach the start value.
- R6: In mode 1, OUT is low while the elapsed ticks are below the start value and high from then on.
- R7: In mode 2, OUT is high for one tick at every non-zero multiple of the start value, and the count reloads to the start value there.
- R8: In mode 3, OUT is high for the first (N+1)/2 ticks of each N-tick period and low for the rest. The visible count steps down by two per tick, modulo N.
- R9: In modes 4 and 5, OUT is high only during the single tick at which the elapsed ticks equal the start value.
- R10: In modes 0 and 4, gate low suspends ticks and a gate rising edge restarts nothing. In modes 1, 2, 3 and 5, a gate rising edge restarts the measurement from zero.
- R11: In modes 0, 1, 4 and 5, the count keeps running past zero and wraps to 0xFFFF in binary format or 9999 in BCD format.
- R12: With bcd_sel=1, load_val and count hold four BCD digits, with the units digit in bits [3:0].
- R13: mode_sel values 6 and 7 behave exactly as modes 2 and 3. mode_sel holds the mode number in binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter-clock enable; each high cycle is one tick |
| gate | input | 1 | Gate input, with a meaning that depends on the mode |
| load | input | 1 | Count-load strobe |
| load_val | input | CNT_W | Start value, binary or BCD |
| mode_sel | input | 3 | Mode number captured at load |
| bcd_sel | input | 1 | 1 selects BCD format at load |
| out | output | 1 | Mode-dependent output waveform |
| count | output | CNT_W | Live count value for readback |

## Verification
The bench builds the channel with its default CNT_W of 16, which gives four BCD digits. This makes both the binary 65536-tick and the BCD 10000-tick zero-load cases reachable within the run. At that width the wrap values 0xFFFF and 9999 can be observed directly. The same width also exercises the odd-period split of the square wave and the alias decoding of mode values 6 and 7.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TC_INT    = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } pit_mode_e;

  // Field values 6 and 7 fold onto the periodic modes 2 and 3.
  function automatic pit_mode_e fold_mode(logic [2:0] raw);
    if (raw[2:1] == 2'b11) return pit_mode_e'({1'b0, raw[1:0]});
    return pit_mode_e'(raw);
  endfunction

endpackage

// File: rtl/pit_load_decode.sv
module pit_load_decode #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] raw,
  input  logic             bcd,
  output logic [CNT_W:0]   ticks,
  output logic [CNT_W:0]   modulus
);
  localparam int DIGITS = CNT_W / 4;
  localparam logic [CNT_W:0] BIN_M = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] BCD_M = (CNT_W+1)'(10 ** DIGITS);

  logic [CNT_W:0] acc;
  logic [CNT_W:0] value;

  always_comb begin
    acc = '0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      acc = (acc << 3) + (acc << 1) + {{(CNT_W-3){1'b0}}, raw[i*4 +: 4]};
    end
    modulus = bcd ? BCD_M : BIN_M;
    value   = bcd ? acc : {1'b0, raw};
    ticks   = (value == '0) ? modulus : value;
  end
endmodule

// File: rtl/pit_phase_core.sv
module pit_phase_core
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  pit_mode_e        ld_mode,
  input  logic             ld_bcd,
  input  logic [CNT_W:0]   ld_ticks,
  input  logic [CNT_W:0]   ld_mod,
  input  logic             cnt_en,
  input  logic             gate,
  output pit_mode_e        mode_q,
  output logic             bcd_q,
  output logic             armed,
  output logic [CNT_W:0]   init_q,
  output logic [CNT_W:0]   mod_q,
  output logic [CNT_W-1:0] phase,
  output logic             reached,
  output logic             at_tc
);
  logic           gate_q;
  logic           gate_rise;
  logic           gated_mode;
  logic           retrig_mode;
  logic           periodic;
  logic           advance;
  logic [CNT_W:0] phase_inc;
  logic           hit;
  logic           wrap;

  always_comb begin
    gate_rise   = gate & ~gate_q;
    gated_mode  = (mode_q == M_TC_INT) || (mode_q == M_SW_STROBE);
    retrig_mode = !gated_mode;
    periodic    = (mode_q == M_RATE) || (mode_q == M_SQUARE);
    advance     = armed && cnt_en && (gate || !gated_mode);
    phase_inc   = {1'b0, phase} + 1'b1;
    hit         = (phase_inc == init_q);
    wrap        = (phase_inc == mod_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= 1'b0;
      mode_q  <= M_TC_INT;
      bcd_q   <= 1'b0;
      armed   <= 1'b0;
      init_q  <= '0;
      mod_q   <= '0;
      phase   <= '0;
      reached <= 1'b0;
      at_tc   <= 1'b0;
    end else begin
      gate_q <= gate;
      if (load) begin
        mode_q  <= ld_mode;
        bcd_q   <= ld_bcd;
        init_q  <= ld_ticks;
        mod_q   <= ld_mod;
        armed   <= 1'b1;
        phase   <= '0;
        reached <= 1'b0;
        at_tc   <= 1'b0;
      end else if (armed && gate_rise && retrig_mode) begin
        phase   <= '0;
        reached <= 1'b0;
        at_tc   <= 1'b0;
      end else if (advance) begin
        if (periodic) begin
          phase <= hit ? '0 : phase_inc[CNT_W-1:0];
          at_tc <= hit;
        end else begin
          phase <= wrap ? '0 : phase_inc[CNT_W-1:0];
          at_tc <= hit && !reached;
          if (hit) reached <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pit_view.sv
module pit_view
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  pit_mode_e        mode_q,
  input  logic             bcd_q,
  input  logic             armed,
  input  logic [CNT_W:0]   init_q,
  input  logic [CNT_W:0]   mod_q,
  input  logic [CNT_W-1:0] phase,
  input  logic             reached,
  input  logic             at_tc,
  output logic [CNT_W-1:0] count,
  output logic             out
);
  localparam int DIGITS = CNT_W / 4;

  function automatic logic [CNT_W-1:0] to_bcd(logic [CNT_W-1:0] b);
    logic [CNT_W-1:0] d;
    d = '0;
    for (int i = CNT_W - 1; i >= 0; i--) begin
      for (int k = 0; k < DIGITS; k++) begin
        if (d[k*4 +: 4] >= 4'd5) d[k*4 +: 4] = d[k*4 +: 4] + 4'd3;
      end
      d = {d[CNT_W-2:0], b[i]};
    end
    return d;
  endfunction

  logic [CNT_W:0]   p_ext;
  logic [CNT_W:0]   dbl;
  logic [CNT_W:0]   diff;
  logic [CNT_W:0]   val;
  logic [CNT_W+1:0] half;
  logic             wave;

  always_comb begin
    p_ext = {1'b0, phase};
    dbl   = {phase, 1'b0};
    half  = ({1'b0, init_q} + 1'b1) >> 1;
    wave  = 1'b0;
    diff  = '0;
    case (mode_q)
      M_RATE: begin
        diff = init_q - p_ext;
        wave = at_tc;
      end
      M_SQUARE: begin
        if (dbl >= init_q) dbl = dbl - init_q;
        diff = init_q - dbl;
        wave = ({1'b0, p_ext} < half);
      end
      M_SW_STROBE, M_HW_STROBE: begin
        diff = (init_q >= p_ext) ? (init_q - p_ext) : (init_q + mod_q - p_ext);
        wave = at_tc;
      end
      default: begin
        diff = (init_q >= p_ext) ? (init_q - p_ext) : (init_q + mod_q - p_ext);
        wave = reached;
      end
    endcase
    val = (diff == mod_q) ? '0 : diff;
    if (!armed) begin
      count = '0;
      out   = 1'b0;
    end else begin
      count = bcd_q ? to_bcd(val[CNT_W-1:0]) : val[CNT_W-1:0];
      out   = wave;
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             gate,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       mode_sel,
  input  logic             bcd_sel,
  output logic             out,
  output logic [CNT_W-1:0] count
);
  pit_mode_e        ld_mode;
  logic [CNT_W:0]   ld_ticks;
  logic [CNT_W:0]   ld_mod;
  pit_mode_e        mode_q;
  logic             bcd_q;
  logic             armed;
  logic [CNT_W:0]   init_q;
  logic [CNT_W:0]   mod_q;
  logic [CNT_W-1:0] phase;
  logic             reached;
  logic             at_tc;

  assign ld_mode = fold_mode(mode_sel);

  pit_load_decode #(.CNT_W(CNT_W)) u_dec (
    .raw(load_val), .bcd(bcd_sel), .ticks(ld_ticks), .modulus(ld_mod)
  );

  pit_phase_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .load(load), .ld_mode(ld_mode), .ld_bcd(bcd_sel),
    .ld_ticks(ld_ticks), .ld_mod(ld_mod), .cnt_en(cnt_en), .gate(gate),
    .mode_q(mode_q), .bcd_q(bcd_q), .armed(armed), .init_q(init_q),
    .mod_q(mod_q), .phase(phase), .reached(reached), .at_tc(at_tc)
  );

  pit_view #(.CNT_W(CNT_W)) u_view (
    .mode_q(mode_q), .bcd_q(bcd_q), .armed(armed), .init_q(init_q),
    .mod_q(mod_q), .phase(phase), .reached(reached), .at_tc(at_tc),
    .count(count), .out(out)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             gate,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic [2:0]       mode_sel,
  input logic             bcd_sel,
  input logic             out,
  input logic [CNT_W-1:0] count
);
  logic       seen_load;
  logic       gate_prev;
  logic [2:0] last_mode;
  logic       g_rise;

  assign g_rise = gate && !gate_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_load <= 1'b0;
      gate_prev <= 1'b0;
      last_mode <= 3'd0;
    end else begin
      gate_prev <= gate;
      if (load) begin
        seen_load <= 1'b1;
        last_mode <= mode_sel;
      end
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk) rst |=> (!out && count == '0));

  // R1
  unloaded_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_load |-> (!out && count == '0));

  // R2
  load_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !bcd_sel && load_val != '0) |=> count == $past(load_val));

  // R3
  zero_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && load_val == '0) |=> count == '0);

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !cnt_en && !g_rise) |=> ($stable(count) && $stable(out)));

  // R5
  tc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_load && last_mode == 3'd0 && out && !load) |=> out);

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_load && (last_mode == 3'd4 || last_mode == 3'd5) && out && cnt_en
     && gate && !load) |=> !out);

  // R7
  rate_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_load && (last_mode == 3'd2 || last_mode == 3'd6) && out && cnt_en
     && !load && count != 1) |=> !out);
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cnt_en = 1'b0;
  logic             gate = 1'b1;
  logic             load = 1'b0;
  logic [CNT_W-1:0] load_val = '0;
  logic [2:0]       mode_sel = '0;
  logic             bcd_sel = 1'b0;
  logic             out;
  logic [CNT_W-1:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pit_channel #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .gate(gate), .load(load),
    .load_val(load_val), .mode_sel(mode_sel), .bcd_sel(bcd_sel),
    .out(out), .count(count)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        bcd;
    logic [15:0] val;
    logic [19:0] n;
    logic [15:0] exp_cnt;
    logic        exp_out;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 16'd5,    20'd0,     16'd5,      1'b0, 8'd5},  // R5
    '{3'd0, 1'b0, 16'd5,    20'd4,     16'd1,      1'b0, 8'd5},  // R5
    '{3'd0, 1'b0, 16'd5,    20'd5,     16'd0,      1'b1, 8'd5},  // R5
    '{3'd0, 1'b0, 16'd5,    20'd7,     16'hFFFE,   1'b1, 8'd11}, // R11
    '{3'd1, 1'b0, 16'd3,    20'd2,     16'd1,      1'b0, 8'd6},  // R6
    '{3'd1, 1'b0, 16'd3,    20'd3,     16'd0,      1'b1, 8'd6},  // R6
    '{3'd2, 1'b0, 16'd4,    20'd3,     16'd1,      1'b0, 8'd7},  // R7
    '{3'd2, 1'b0, 16'd4,    20'd4,     16'd4,      1'b1, 8'd7},  // R7
    '{3'd2, 1'b0, 16'd4,    20'd5,     16'd3,      1'b0, 8'd7},  // R7
    '{3'd3, 1'b0, 16'd5,    20'd0,     16'd5,      1'b1, 8'd8},  // R8
    '{3'd3, 1'b0, 16'd5,    20'd2,     16'd1,      1'b1, 8'd8},  // R8
    '{3'd3, 1'b0, 16'd5,    20'd3,     16'd4,      1'b0, 8'd8},  // R8
    '{3'd3, 1'b0, 16'd5,    20'd5,     16'd5,      1'b1, 8'd8},  // R8
    '{3'd4, 1'b0, 16'd3,    20'd2,     16'd1,      1'b0, 8'd9},  // R9
    '{3'd4, 1'b0, 16'd3,    20'd3,     16'd0,      1'b1, 8'd9},  // R9
    '{3'd4, 1'b0, 16'd3,    20'd4,     16'hFFFF,   1'b0, 8'd9},  // R9
    '{3'd5, 1'b0, 16'd2,    20'd2,     16'd0,      1'b1, 8'd9},  // R9
    '{3'd6, 1'b0, 16'd4,    20'd4,     16'd4,      1'b1, 8'd13}, // R13
    '{3'd7, 1'b0, 16'd4,    20'd2,     16'd4,      1'b0, 8'd13}, // R13
    '{3'd0, 1'b1, 16'h0012, 20'd3,     16'h0009,   1'b0, 8'd12}, // R12
    '{3'd0, 1'b1, 16'h0012, 20'd12,    16'h0000,   1'b1, 8'd12}, // R12
    '{3'd0, 1'b1, 16'h0012, 20'd13,    16'h9999,   1'b1, 8'd11}, // R11
    '{3'd2, 1'b1, 16'h0010, 20'd3,     16'h0007,   1'b0, 8'd12}, // R12
    '{3'd0, 1'b1, 16'h0100, 20'd1,     16'h0099,   1'b0, 8'd12}, // R12
    '{3'd0, 1'b0, 16'h0000, 20'd65536, 16'h0000,   1'b1, 8'd3},  // R3
    '{3'd0, 1'b1, 16'h0000, 20'd9999,  16'h0001,   1'b0, 8'd3},  // R3
    '{3'd0, 1'b1, 16'h0000, 20'd10000, 16'h0000,   1'b1, 8'd3}   // R3
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] m, input logic b, input logic [15:0] v);
    @(negedge clk);
    mode_sel = m; bcd_sel = b; load_val = v; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic tick(input int n);
    if (n > 0) begin
      @(negedge clk);
      cnt_en = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk);
    gate = v;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset count", int'(count), 0);
    chk("R1 reset out", int'(out), 0);

    // R1: no load yet, ticks and gate edges do nothing
    tick(5);
    set_gate(1'b0);
    set_gate(1'b1);
    @(negedge clk);
    chk("R1 unloaded count", int'(count), 0);
    chk("R1 unloaded out", int'(out), 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i].mode, VEC[i].bcd, VEC[i].val);
      tick(int'(VEC[i].n));
      chk($sformatf("R%0d row %0d count", VEC[i].req, i), int'(count), int'(VEC[i].exp_cnt));
      chk($sformatf("R%0d row %0d out", VEC[i].req, i), int'(out), int'(VEC[i].exp_out));
    end

    // R4: cnt_en low holds the count
    do_load(3'd0, 1'b0, 16'd9);
    repeat (4) @(negedge clk);
    chk("R4 held without cnt_en", int'(count), 9);
    tick(1);
    chk("R4 one tick", int'(count), 8);

    // R10: mode 0 gate suspends, rising edge does not restart
    do_load(3'd0, 1'b0, 16'd5);
    tick(2);
    set_gate(1'b0);
    tick(3);
    chk("R10 mode0 gate low suspends", int'(count), 3);
    set_gate(1'b1);
    @(negedge clk);
    chk("R10 mode0 rise no restart", int'(count), 3);
    tick(1);
    chk("R10 mode0 resumes", int'(count), 2);

    // R6 / R10: mode 1 gate rising edge retriggers
    do_load(3'd1, 1'b0, 16'd5);
    tick(3);
    set_gate(1'b0);
    set_gate(1'b1);
    @(negedge clk);
    chk("R6 mode1 retrigger count", int'(count), 5);
    chk("R6 mode1 retrigger out", int'(out), 0);
    tick(5);
    chk("R6 mode1 expiry out", int'(out), 1);

    // R10: mode 4 gate low suspends
    do_load(3'd4, 1'b0, 16'd3);
    set_gate(1'b0);
    tick(3);
    chk("R10 mode4 gate low count", int'(count), 3);
    chk("R10 mode4 gate low out", int'(out), 0);
    set_gate(1'b1);

    // R10: mode 2 gate rising edge restarts
    do_load(3'd2, 1'b0, 16'd4);
    tick(2);
    set_gate(1'b0);
    set_gate(1'b1);
    @(negedge clk);
    chk("R10 mode2 restart", int'(count), 4);

    // R9 / R10: mode 5 gate rising edge restarts
    do_load(3'd5, 1'b0, 16'd3);
    tick(2);
    set_gate(1'b0);
    set_gate(1'b1);
    @(negedge clk);
    chk("R10 mode5 restart", int'(count), 3);

    // R2: a new load discards the running count
    do_load(3'd0, 1'b0, 16'd5);
    tick(5);
    do_load(3'd0, 1'b0, 16'd7);
    chk("R2 reload count", int'(count), 7);
    chk("R2 reload out", int'(out), 0);

    // R1: reset mid-run
    do_load(3'd3, 1'b0, 16'd5);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-run reset out", int'(out), 0);
    chk("R1 mid-run reset count", int'(count), 0);

    done = 1'b1;
    summary();
  end
endmodule